// File: doc/BRIEF.md
# Ping-Pong Buffered Peripheral DMA Channel

This block is one peripheral DMA channel that moves data between memory and a single fixed device. It has two buffer slots. Each slot holds a current address and a remaining byte count. Software loads the idle slot while the other one runs, then arms it by writing a one to that slot's start bit through a write-one-to-set alias of the control/status word.

When the device asks for data, the channel moves one unit per beat. The unit is one byte or one 16-bit halfword, chosen by the device-attribute register. On each beat the active slot's address advances and its count drops. When a slot runs out, its start bit falls and its sticky done bit rises. If the other slot is armed, a buffer-in-use bit flips and the next beat comes from the other slot without a gap. Software reads the current-address register of the slot in use to work out how many bytes remain.

A small memory-mapped register window gives access to the channel:

| Byte offset | Register |
|---|---|
| 0x00 | device attribute |
| 0x04 | control/status set alias |
| 0x08 | control/status clear alias |
| 0x0C | control/status read view |
| 0x10 | slot A address |
| 0x14 | slot A count |
| 0x18 | slot B address |
| 0x1C | slot B count |

An interrupt line summarises the sticky status bits.

Top module: `dma_pp_channel`

## Requirements
- R1: After reset the control/status word, both slot addresses and both slot counts read 0, irq is 0 and dev_ack is 0.
- R2: The control/status bit positions are run=0, irq_en=1, error=2, done_a=3, start_a=4, done_b=5, start_b=6 and in_use=7 (0 selects slot A, 1 selects slot B).
  - A write to offset 0x04 sets each of run, irq_en, start_a and start_b whose write-data bit is 1.
  - A write to offset 0x08 clears each of bits 0 to 6 whose write-data bit is 1.
  - Write-data bits that are 0 change nothing, and the set alias cannot set error, done_a, done_b or in_use.
- R3: dev_ack is 1 exactly when dev_req is 1, run is 1 and the slot selected by in_use is started. Each such beat accesses mem_addr equal to the active slot's current address. At the clock edge that ends the beat, that address grows by the step and the count falls by the step. The step is 2 bytes when attribute bit 3 is 1 and 1 byte when it is 0.
- R4: On the beat that brings the active count to zero, the active start bit clears and its done bit sets. If the other slot is started at that moment, in_use toggles and the very next cycle can beat from the other slot's address. Otherwise dev_ack stays 0 and in_use is unchanged.
- R5: done_a, done_b and error stay set until a clear-alias write with a 1 in their bit position.
- R6: irq is 1 whenever irq_en is 1 and at least one of error, done_a and done_b is 1. Otherwise irq is 0.
- R7: While run is 0 no beat occurs and the active address and count hold their values. Setting run again continues from the held address.
- R8: Arming a slot whose count is 0 sets that slot's done bit on the next cycle, leaves its start bit at 0, and produces no beat.
- R9: Arming a slot whose address has nonzero bits [1:0] sets error and leaves the start bit at 0.
- R10: If the slot selected by in_use is not started while the other slot is, in_use toggles at the next clock edge.
- R11: Data path and direction.
  - Attribute bit 0 gives the direction. With bit 0 = 1 (device to memory), a beat drives mem_we=1 and mem_wdata is derived from dev_rdata. With bit 0 = 0, mem_we=0 and dev_wdata is derived from mem_rdata.
  - With bit 3 = 0 only the low byte passes and the upper byte is 0.
  - With bit 3 = 1 the halfword passes unchanged when bit 1 is 0, and byte-swapped when bit 1 is 1.
- R12: The attribute register at offset 0x00 reads back all 32 written bits. dev_port always equals attribute bits [7:4].
- R13: Register reads and writes.
  - Offset 0x0C reads the control/status word in bits [7:0].
  - Offsets 0x10 and 0x18 read the current addresses of slots A and B. Offsets 0x14 and 0x1C read their remaining 13-bit counts.
  - Writes whose byte offset has nonzero bits [1:0] are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| irq | output | 1 | Interrupt request |
| dev_req | input | 1 | Device requests one beat |
| dev_ack | output | 1 | Beat taken this cycle |
| dev_port | output | 4 | Selected device port |
| dev_rdata | input | 16 | Data from the device |
| dev_wdata | output | 16 | Data to the device |
| mem_en | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Memory access is a write |
| mem_wide | output | 1 | Access is 16 bits wide |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 16 | Data to memory |
| mem_rdata | input | 16 | Data from memory |

## Verification
A wrong in_use bit or a lost start bit shows on the first beat after a slot hand-off. Either mem_addr jumps to the wrong slot's address in that cycle, or dev_ack falls while dev_req is still high. A counter that decrements wrongly moves the completion edge. The done bit and irq then rise one or more cycles early or late, and the count read back at offset 0x14 or 0x1C differs right away. A status update with the wrong priority appears on the control/status word one cycle after the write that triggered it.

// File: rtl/dma_pp_pkg.sv
package dma_pp_pkg;
  localparam int ST_RUN   = 0;
  localparam int ST_IE    = 1;
  localparam int ST_ERR   = 2;
  localparam int ST_DONEA = 3;
  localparam int ST_STRTA = 4;
  localparam int ST_DONEB = 5;
  localparam int ST_STRTB = 6;
  localparam int ST_BIU   = 7;

  localparam int AT_DIR  = 0;
  localparam int AT_BIG  = 1;
  localparam int AT_WIDE = 3;

  typedef enum logic [2:0] {
    RG_ATTR = 3'd0,
    RG_SET  = 3'd1,
    RG_CLR  = 3'd2,
    RG_STAT = 3'd3,
    RG_ADRA = 3'd4,
    RG_CNTA = 3'd5,
    RG_ADRB = 3'd6,
    RG_CNTB = 3'd7
  } reg_idx_e;
endpackage

// File: rtl/dma_pp_slot.sv
module dma_pp_slot #(
  parameter int AW     = 32,
  parameter int CW     = 13,
  parameter int STEP_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_addr,
  input  logic              ld_cnt,
  input  logic [AW-1:0]     wdata,
  input  logic              adv,
  input  logic [STEP_W-1:0] step,
  output logic [AW-1:0]     addr,
  output logic [CW-1:0]     cnt,
  output logic              last,
  output logic              empty,
  output logic              misal
);
  logic [AW-1:0] addr_q, addr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          en;

  always_comb begin
    addr_d = addr_q;
    cnt_d  = cnt_q;
    if (ld_addr)  addr_d = wdata;
    else if (adv) addr_d = addr_q + AW'(step);
    if (ld_cnt)   cnt_d = wdata[CW-1:0];
    else if (adv) cnt_d = (cnt_q > CW'(step)) ? cnt_q - CW'(step) : '0;
    en = ld_addr | ld_cnt | adv;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      cnt_q  <= '0;
    end else if (en) begin
      addr_q <= addr_d;
      cnt_q  <= cnt_d;
    end
  end

  assign addr  = addr_q;
  assign cnt   = cnt_q;
  assign last  = (cnt_q <= CW'(step));
  assign empty = (cnt_q == '0);
  assign misal = (addr_q[1:0] != 2'b00);
endmodule

// File: rtl/dma_pp_ctrl.sv
module dma_pp_ctrl
  import dma_pp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       set_wr,
  input  logic       clr_wr,
  input  logic [6:0] wbits,
  input  logic       dev_req,
  input  logic       last_a,
  input  logic       last_b,
  input  logic       empty_a,
  input  logic       empty_b,
  input  logic       misal_a,
  input  logic       misal_b,
  output logic [7:0] status,
  output logic       beat,
  output logic       irq
);
  logic [7:0] st_q, st_d;
  logic       act_start, oth_start, act_last, st_en;

  assign act_start = st_q[ST_BIU] ? st_q[ST_STRTB] : st_q[ST_STRTA];
  assign oth_start = st_q[ST_BIU] ? st_q[ST_STRTA] : st_q[ST_STRTB];
  assign act_last  = st_q[ST_BIU] ? last_b : last_a;
  assign beat      = dev_req & st_q[ST_RUN] & act_start;

  always_comb begin
    st_d = st_q;
    if (clr_wr) st_d[6:0] = st_q[6:0] & ~wbits;
    if (beat && act_last) begin
      if (st_q[ST_BIU]) begin
        st_d[ST_STRTB] = 1'b0;
        st_d[ST_DONEB] = 1'b1;
      end else begin
        st_d[ST_STRTA] = 1'b0;
        st_d[ST_DONEA] = 1'b1;
      end
      if (oth_start) st_d[ST_BIU] = ~st_q[ST_BIU];
    end else if (!act_start && oth_start) begin
      st_d[ST_BIU] = ~st_q[ST_BIU];
    end
    if (set_wr) begin
      if (wbits[ST_RUN]) st_d[ST_RUN] = 1'b1;
      if (wbits[ST_IE])  st_d[ST_IE]  = 1'b1;
      if (wbits[ST_STRTA]) begin
        if (misal_a)      st_d[ST_ERR]   = 1'b1;
        else if (empty_a) st_d[ST_DONEA] = 1'b1;
        else              st_d[ST_STRTA] = 1'b1;
      end
      if (wbits[ST_STRTB]) begin
        if (misal_b)      st_d[ST_ERR]   = 1'b1;
        else if (empty_b) st_d[ST_DONEB] = 1'b1;
        else              st_d[ST_STRTB] = 1'b1;
      end
    end
    st_en = (st_d != st_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     st_q <= '0;
    else if (st_en) st_q <= st_d;
  end

  assign status = st_q;
  assign irq    = st_q[ST_IE] & (st_q[ST_ERR] | st_q[ST_DONEA] | st_q[ST_DONEB]);
endmodule

// File: rtl/dma_pp_data.sv
module dma_pp_data #(
  parameter int DW = 16
) (
  input  logic          dir_in,
  input  logic          big,
  input  logic          wide,
  input  logic [DW-1:0] dev_rdata,
  input  logic [DW-1:0] mem_rdata,
  output logic [DW-1:0] mem_wdata,
  output logic [DW-1:0] dev_wdata
);
  localparam int NB = DW / 8;

  logic [DW-1:0] dev_sw, mem_sw;

  generate
    for (genvar i = 0; i < NB; i++) begin : g_swap
      assign dev_sw[8*i +: 8] = dev_rdata[8*(NB-1-i) +: 8];
      assign mem_sw[8*i +: 8] = mem_rdata[8*(NB-1-i) +: 8];
    end
  endgenerate

  always_comb begin
    if (!wide) begin
      mem_wdata = {{(DW-8){1'b0}}, dev_rdata[7:0]};
      dev_wdata = {{(DW-8){1'b0}}, mem_rdata[7:0]};
    end else if (big) begin
      mem_wdata = dev_sw;
      dev_wdata = mem_sw;
    end else begin
      mem_wdata = dev_rdata;
      dev_wdata = mem_rdata;
    end
    if (dir_in) dev_wdata = '0;
  end
endmodule

// File: rtl/dma_pp_channel.sv
module dma_pp_channel
  import dma_pp_pkg::*;
#(
  parameter int AW     = 32,
  parameter int CW     = 13,
  parameter int DW     = 16,
  parameter int REG_AW = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              irq,
  input  logic              dev_req,
  output logic              dev_ack,
  output logic [3:0]        dev_port,
  input  logic [DW-1:0]     dev_rdata,
  output logic [DW-1:0]     dev_wdata,
  output logic              mem_en,
  output logic              mem_we,
  output logic              mem_wide,
  output logic [AW-1:0]     mem_addr,
  output logic [DW-1:0]     mem_wdata,
  input  logic [DW-1:0]     mem_rdata
);
  localparam int STEP_W = $clog2(DW / 8) + 1;

  logic [1:0]        rst_sync;
  logic              rst_int_n;
  logic [2:0]        idx;
  logic              wr_ok;
  logic [31:0]       attr_q;
  logic [7:0]        status;
  logic              beat;
  logic [STEP_W-1:0] step;
  logic [AW-1:0]     s_addr [2];
  logic [CW-1:0]     s_cnt  [2];
  logic [1:0]        s_last, s_empty, s_misal;
  logic              biu;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  assign idx   = reg_addr[4:2];
  assign wr_ok = reg_wr & (reg_addr[1:0] == 2'b00);
  assign step  = attr_q[AT_WIDE] ? STEP_W'(DW / 8) : STEP_W'(1);
  assign biu   = status[ST_BIU];

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)                         attr_q <= '0;
    else if (wr_ok && idx == 3'(RG_ATTR))   attr_q <= reg_wdata;
  end

  generate
    for (genvar g = 0; g < 2; g++) begin : g_slot
      dma_pp_slot #(.AW(AW), .CW(CW), .STEP_W(STEP_W)) slot_i (
        .clk     (clk),
        .rst_n   (rst_int_n),
        .ld_addr (wr_ok && idx == (g == 0 ? 3'(RG_ADRA) : 3'(RG_ADRB))),
        .ld_cnt  (wr_ok && idx == (g == 0 ? 3'(RG_CNTA) : 3'(RG_CNTB))),
        .wdata   (reg_wdata[AW-1:0]),
        .adv     (beat && (biu == (g != 0))),
        .step    (step),
        .addr    (s_addr[g]),
        .cnt     (s_cnt[g]),
        .last    (s_last[g]),
        .empty   (s_empty[g]),
        .misal   (s_misal[g])
      );
    end
  endgenerate

  dma_pp_ctrl ctrl_i (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .set_wr  (wr_ok && idx == 3'(RG_SET)),
    .clr_wr  (wr_ok && idx == 3'(RG_CLR)),
    .wbits   (reg_wdata[6:0]),
    .dev_req (dev_req),
    .last_a  (s_last[0]),
    .last_b  (s_last[1]),
    .empty_a (s_empty[0]),
    .empty_b (s_empty[1]),
    .misal_a (s_misal[0]),
    .misal_b (s_misal[1]),
    .status  (status),
    .beat    (beat),
    .irq     (irq)
  );

  dma_pp_data #(.DW(DW)) data_i (
    .dir_in    (attr_q[AT_DIR]),
    .big       (attr_q[AT_BIG]),
    .wide      (attr_q[AT_WIDE]),
    .dev_rdata (dev_rdata),
    .mem_rdata (mem_rdata),
    .mem_wdata (mem_wdata),
    .dev_wdata (dev_wdata)
  );

  assign dev_ack  = beat;
  assign mem_en   = beat;
  assign mem_we   = beat & attr_q[AT_DIR];
  assign mem_wide = attr_q[AT_WIDE];
  assign mem_addr = biu ? s_addr[1] : s_addr[0];
  assign dev_port = attr_q[7:4];

  always_comb begin
    case (idx)
      3'(RG_ATTR): reg_rdata = attr_q;
      3'(RG_STAT): reg_rdata = {24'h0, status};
      3'(RG_ADRA): reg_rdata = 32'(s_addr[0]);
      3'(RG_CNTA): reg_rdata = 32'(s_cnt[0]);
      3'(RG_ADRB): reg_rdata = 32'(s_addr[1]);
      3'(RG_CNTB): reg_rdata = 32'(s_cnt[1]);
      default:     reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/dma_pp_channel_chk.sv
module dma_pp_channel_chk #(
  parameter int AW     = 32,
  parameter int CW     = 13,
  parameter int STEP_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [4:0]        reg_addr,
  input logic [31:0]       reg_wdata,
  input logic              dev_req,
  input logic              dev_ack,
  input logic              irq,
  input logic [7:0]        status,
  input logic [AW-1:0]     addr_a,
  input logic [CW-1:0]     cnt_a,
  input logic [STEP_W-1:0] step
);
  // R3
  assert_ack_needs_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
    dev_ack |-> dev_req);

  // R3
  assert_addr_advance_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_ack && !status[7] && !reg_wr) |=> addr_a == $past(addr_a) + AW'($past(step)));

  // R7
  assert_hold_when_stopped_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!status[0] && !reg_wr) |=> ($stable(addr_a) && $stable(cnt_a)));

  // R5
  assert_done_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (status[3] && !(reg_wr && reg_addr == 5'h08 && reg_wdata[3])) |=> status[3]);

  // R6
  assert_irq_on_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (status[1] && (status[3] || status[5] || status[2])) |-> irq);

  // R8
  assert_zero_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 5'h04 && reg_wdata[4] && cnt_a == '0 && addr_a[1:0] == 2'b00)
    |=> (status[3] && !status[4]));
endmodule

bind dma_pp_channel dma_pp_channel_chk #(.AW(AW), .CW(CW), .STEP_W(STEP_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .dev_req   (dev_req),
  .dev_ack   (dev_ack),
  .irq       (irq),
  .status    (status),
  .addr_a    (s_addr[0]),
  .cnt_a     (s_cnt[0]),
  .step      (step)
);

// File: tb/dma_pp_channel_tb_top.sv
`timescale 1ns/1ps
module dma_pp_channel_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq, dev_req = 1'b0, dev_ack;
  logic [3:0]  dev_port;
  logic [15:0] dev_rdata = 16'hABCD, dev_wdata;
  logic        mem_en, mem_we, mem_wide;
  logic [31:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata = 16'h1234;

  int checks = 0;
  int errors = 0;

  localparam logic [2:0] I_ATTR = 3'd0, I_SET = 3'd1, I_CLR = 3'd2, I_STAT = 3'd3,
                         I_ADRA = 3'd4, I_CNTA = 3'd5, I_ADRB = 3'd6, I_CNTB = 3'd7;

  always #5 clk = ~clk;

  dma_pp_channel dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .dev_req(dev_req), .dev_ack(dev_ack), .dev_port(dev_port),
    .dev_rdata(dev_rdata), .dev_wdata(dev_wdata), .mem_en(mem_en),
    .mem_we(mem_we), .mem_wide(mem_wide), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] idx, input logic [31:0] data);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = {idx, 2'b00}; reg_wdata = data;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] idx, output logic [31:0] data);
    reg_addr = {idx, 2'b00};
    #1;
    data = reg_rdata;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(I_STAT, v); check("R1 status", v, 0);
    rd(I_ADRA, v); check("R1 addr A", v, 0);
    rd(I_CNTB, v); check("R1 count B", v, 0);
    check("R1 irq", {31'b0, irq}, 0);
    check("R1 ack", {31'b0, dev_ack}, 0);
  endtask

  task automatic t_single;
    logic [31:0] v;
    wr(I_ATTR, 32'h1);
    wr(I_ADRA, 32'h100);
    wr(I_CNTA, 32'h3);
    wr(I_SET, 32'h13);
    dev_req = 1'b1;
    for (int i = 0; i < 3; i++) begin
      #1;
      check("R3 ack", {31'b0, dev_ack}, 1);
      check("R3 mem_addr byte step", mem_addr, 32'h100 + i);
      check("R11 mem_we dev to mem", {31'b0, mem_we}, 1);
      check("R11 narrow low byte", {16'h0, mem_wdata}, 32'h00CD);
      @(negedge clk);
    end
    #1;
    check("R4 no ack after last", {31'b0, dev_ack}, 0);
    dev_req = 1'b0;
    rd(I_STAT, v); check("R4 done A set start cleared", v, 32'h0B);
    check("R6 irq on done", {31'b0, irq}, 1);
    rd(I_ADRA, v); check("R13 addr A advanced", v, 32'h103);
    rd(I_CNTA, v); check("R13 count A zero", v, 0);
    wr(I_CLR, 32'h0);
    rd(I_STAT, v); check("R2 clear with zero bits", v, 32'h0B);
    wr(I_SET, 32'hAC);
    rd(I_STAT, v); check("R2 set alias cannot set sticky or in_use", v, 32'h0B);
    // R13: a write at a misaligned offset is ignored
    @(negedge clk); reg_wr = 1'b1; reg_addr = 5'h09; reg_wdata = 32'h08;
    @(negedge clk); reg_wr = 1'b0;
    rd(I_STAT, v); check("R13 misaligned write ignored", v, 32'h0B);
    wr(I_CLR, 32'h08);
    rd(I_STAT, v); check("R5 cleared by clear alias", v, 32'h03);
    check("R6 irq drops", {31'b0, irq}, 0);
  endtask

  task automatic t_pingpong;
    logic [31:0] v;
    logic [31:0] exp_a [3];
    exp_a[0] = 32'h200; exp_a[1] = 32'h202; exp_a[2] = 32'h300;
    wr(I_ATTR, 32'h9);
    wr(I_ADRA, 32'h200); wr(I_CNTA, 32'h4);
    wr(I_ADRB, 32'h300); wr(I_CNTB, 32'h2);
    wr(I_SET, 32'h50);
    dev_req = 1'b1;
    for (int i = 0; i < 3; i++) begin
      #1;
      check("R4 gapless ack", {31'b0, dev_ack}, 1);
      check("R4 hand-off address", mem_addr, exp_a[i]);
      check("R11 wide little", {16'h0, mem_wdata}, 32'hABCD);
      @(negedge clk);
    end
    #1;
    check("R4 stop when other idle", {31'b0, dev_ack}, 0);
    dev_req = 1'b0;
    rd(I_STAT, v); check("R4 both done, in_use B", v, 32'hAB);
  endtask

  task automatic t_idle_switch;
    logic [31:0] v;
    wr(I_CLR, 32'h7F);
    rd(I_STAT, v); check("R2 clear keeps in_use", v, 32'h80);
    wr(I_ATTR, 32'hB);
    wr(I_ADRA, 32'h400); wr(I_CNTA, 32'h2);
    wr(I_SET, 32'h11);
    rd(I_STAT, v); check("R10 before switch", v, 32'h91);
    @(negedge clk);
    rd(I_STAT, v); check("R10 switched to A", v, 32'h11);
    dev_req = 1'b1; #1;
    check("R10 beat from A", mem_addr, 32'h400);
    check("R11 wide big swap", {16'h0, mem_wdata}, 32'hCDAB);
    @(negedge clk); dev_req = 1'b0;
    rd(I_STAT, v); check("R4 done after one wide beat", v, 32'h09);
  endtask

  task automatic t_hold;
    logic [31:0] v;
    wr(I_CLR, 32'h7F);
    wr(I_ATTR, 32'h0);
    wr(I_ADRA, 32'h500); wr(I_CNTA, 32'h8);
    wr(I_SET, 32'h11);
    dev_req = 1'b1;
    for (int i = 0; i < 2; i++) begin
      #1;
      check("R11 mem_we read", {31'b0, mem_we}, 0);
      check("R11 narrow to device", {16'h0, dev_wdata}, 32'h0034);
      @(negedge clk);
    end
    dev_req = 1'b0;
    wr(I_CLR, 32'h01);
    dev_req = 1'b1;
    for (int i = 0; i < 3; i++) begin
      #1; check("R7 no beat when stopped", {31'b0, dev_ack}, 0);
      @(negedge clk);
    end
    dev_req = 1'b0;
    rd(I_ADRA, v); check("R7 address held", v, 32'h502);
    rd(I_CNTA, v); check("R7 count held", v, 32'h6);
    wr(I_SET, 32'h01);
    dev_req = 1'b1; #1;
    check("R7 resume ack", {31'b0, dev_ack}, 1);
    check("R7 resume address", mem_addr, 32'h502);
    @(negedge clk); dev_req = 1'b0;
    rd(I_CNTA, v); check("R3 count decremented", v, 32'h5);
    wr(I_CLR, 32'h7F);
    wr(I_ATTR, 32'hA);
    #1; check("R11 wide big to device", {16'h0, dev_wdata}, 32'h3412);
  endtask

  task automatic t_zero_misal;
    logic [31:0] v;
    wr(I_ADRB, 32'h600); wr(I_CNTB, 32'h0);
    wr(I_SET, 32'h40);
    rd(I_STAT, v); check("R8 zero count done B, no start", v, 32'h20);
    dev_req = 1'b1; #1;
    check("R8 no beat", {31'b0, dev_ack}, 0);
    dev_req = 1'b0;
    wr(I_ADRA, 32'h702); wr(I_CNTA, 32'h4);
    wr(I_SET, 32'h12);
    rd(I_STAT, v); check("R9 error set, no start", v, 32'h26);
    check("R6 irq on error", {31'b0, irq}, 1);
  endtask

  task automatic t_attr;
    logic [31:0] v;
    wr(I_ATTR, 32'hDEADBEA5);
    rd(I_ATTR, v); check("R12 attr readback", v, 32'hDEADBEA5);
    check("R12 dev_port", {28'h0, dev_port}, 32'hA);
  endtask

  initial begin
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_single();
    t_pingpong();
    t_idle_switch();
    t_hold();
    t_zero_misal();
    t_attr();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule